// File: doc/BRIEF.md
# Decimal 6:2 Reduction Tree in 4221 Code

This block takes six decimal operand rows, every digit held in the 4221 weighted code, and reduces them to two rows whose decimal sum equals the sum of all six inputs. It is the back half of a parallel decimal multiplier's partial product reduction. It sits after the stage that turns partial products into 4221 rows and before a carry-propagate decimal adder. The block is purely combinational.

Each reduction level uses a row of digit-wise decimal 3:2 compressors. A compressor is four binary full adders, one per bit position. Because every bit position of a 4221 digit has a fixed weight, the full adders give a sum digit and a carry digit that are both valid 4221 digits. The carry digit carries twice its own weight, so it passes through a decimal doubling unit. That unit recodes the digit to the 5211 code and shifts it left by one bit. The bit shifted out becomes a decimal carry into the weight-1 position of the next column's doubled digit.

Three levels reduce 6 rows to 4, 4 rows to 3, and 3 rows to 2. Both output rows are also given in plain 8421 BCD, ready for the final adder.

Top module: `dec4221_tree62`

## Requirements
- R1: A 4221 digit has bit 3 of weight 4, bits 2 and 1 of weight 2 each, and bit 0 of weight 1. Every one of the 16 bit patterns is a legal digit with a value from 0 to 9, and the block accepts any of them on any input digit.
- R2: Each digit compressor takes three 4221 digits a, b, c and produces a sum digit s and a carry digit h, both in 4221, such that a+b+c = s + 2h.
- R3: The doubling unit maps a carry digit h and an incoming carry bit ci to a 4221 digit q and an outgoing carry bit co, such that 2h + ci = 10co + q. Bit ci lands in bit 0 (weight 1) of q. Bit co feeds the next more significant column.
- R4: The decimal value of sum_row plus the decimal value of dbl_row equals the decimal sum of the six input rows. Digit 0 is the least significant digit and sits in bits [3:0].
- R5: The output rows are one digit wider than the inputs. No doubling carry is ever lost out of the most significant output column, including when every input digit is 9.
- R6: sum_bcd and dbl_bcd hold, digit for digit, the values of sum_row and dbl_row in 8421 BCD. Each digit is in the range 0 to 9.
- R7: Bit 0 of the least significant digit of dbl_row is always 0, because no carry enters column 0.
- R8: Different 4221 patterns for the same digit values (for example 0110 and 1000, both 4) give output rows with the same decoded total.
- R9: All-zero inputs give all-zero outputs on all four output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| row0 | input | 4*DIGITS | Operand row 0, 4221 digits |
| row1 | input | 4*DIGITS | Operand row 1, 4221 digits |
| row2 | input | 4*DIGITS | Operand row 2, 4221 digits |
| row3 | input | 4*DIGITS | Operand row 3, 4221 digits |
| row4 | input | 4*DIGITS | Operand row 4, 4221 digits |
| row5 | input | 4*DIGITS | Operand row 5, 4221 digits |
| sum_row | output | 4*(DIGITS+1) | Reduced sum row, 4221 digits |
| dbl_row | output | 4*(DIGITS+1) | Reduced doubled-carry row, 4221 digits |
| sum_bcd | output | 4*(DIGITS+1) | sum_row in 8421 BCD |
| dbl_bcd | output | 4*(DIGITS+1) | dbl_row in 8421 BCD |

## Verification
The bench drives all nines on every row, which forces the largest doubling carries. A design that dropped the top column or gave the output rows too few digits would then lose a power of ten from the total. It also drives redundant patterns such as 0110 against 1000, and all sixteen raw patterns at random. A doubling unit that decoded only the canonical codes would give a wrong carry or a wrong digit there. Vectors in which a single row is non-zero, and sparse vectors, expose a carry bit routed into the wrong column or into the wrong bit weight. These show up as totals off by a digit-position factor. Checking the 8421 outputs against the 4221 rows catches a converter that weights bit 1 or bit 2 wrongly.

// File: rtl/dec4221_pkg.sv
package dec4221_pkg;

    localparam int DIG_BITS = 4;

    // Value of a 4221 digit (weights 4,2,2,1), always 0..9
    function automatic logic [3:0] val4221(input logic [3:0] d);
        logic [3:0] v;
        v = {1'b0, d[3], 2'b00} + {2'b00, d[2], 1'b0}
          + {2'b00, d[1], 1'b0} + {3'b000, d[0]};
        return v;
    endfunction

    // Canonical 5211 code (bit 3 weight 5, bits 2..0 weights 2,1,1)
    function automatic logic [3:0] code5211(input logic [3:0] v);
        logic       hi;
        logic [3:0] r;
        logic [2:0] lo;
        hi = (v >= 4'd5);
        r  = hi ? (v - 4'd5) : v;
        unique case (r)
            4'd0:    lo = 3'b000;
            4'd1:    lo = 3'b001;
            4'd2:    lo = 3'b100;
            4'd3:    lo = 3'b101;
            default: lo = 3'b111;
        endcase
        return {hi, lo};
    endfunction

endpackage

// File: rtl/dec_csa_digit.sv
module dec_csa_digit
    import dec4221_pkg::*;
(
    input  logic [3:0] a_dig,
    input  logic [3:0] b_dig,
    input  logic [3:0] c_dig,
    output logic [3:0] s_dig,
    output logic [3:0] h_dig
);

    always_comb begin
        for (int k = 0; k < DIG_BITS; k++) begin
            s_dig[k] = a_dig[k] ^ b_dig[k] ^ c_dig[k];
            h_dig[k] = (a_dig[k] & b_dig[k]) | (a_dig[k] & c_dig[k])
                     | (b_dig[k] & c_dig[k]);
        end
        // R2
        csa_identity_chk: assert (int'(val4221(a_dig)) + int'(val4221(b_dig))
                                  + int'(val4221(c_dig))
                                  == int'(val4221(s_dig)) + 2 * int'(val4221(h_dig)));
    end

endmodule

// File: rtl/dec_x2_digit.sv
module dec_x2_digit
    import dec4221_pkg::*;
(
    input  logic [3:0] h_dig,
    input  logic       cy_in,
    output logic [3:0] q_dig,
    output logic       cy_out
);

    logic [3:0] rec;

    always_comb begin
        rec    = code5211(val4221(h_dig));
        cy_out = rec[3];
        q_dig  = {rec[2:0], cy_in};
        // R3
        x2_identity_chk: assert (2 * int'(val4221(h_dig)) + int'(cy_in)
                                 == 10 * int'(cy_out) + int'(val4221(q_dig)));
    end

endmodule

// File: rtl/dec_csa_row.sv
module dec_csa_row #(
    parameter int NDIG = 17
) (
    input  logic [4*NDIG-1:0] a_row,
    input  logic [4*NDIG-1:0] b_row,
    input  logic [4*NDIG-1:0] c_row,
    output logic [4*NDIG-1:0] s_row,
    output logic [4*NDIG-1:0] d_row,
    output logic              top_cy
);

    logic [NDIG:0]     cy;
    logic [4*NDIG-1:0] h_row;

    assign cy[0]  = 1'b0;
    assign top_cy = cy[NDIG];

    for (genvar i = 0; i < NDIG; i++) begin : g_col
        dec_csa_digit u_csa (
            .a_dig (a_row[4*i +: 4]),
            .b_dig (b_row[4*i +: 4]),
            .c_dig (c_row[4*i +: 4]),
            .s_dig (s_row[4*i +: 4]),
            .h_dig (h_row[4*i +: 4])
        );
        dec_x2_digit u_x2 (
            .h_dig  (h_row[4*i +: 4]),
            .cy_in  (cy[i]),
            .q_dig  (d_row[4*i +: 4]),
            .cy_out (cy[i+1])
        );
    end

endmodule

// File: rtl/dec4221_to_8421.sv
module dec4221_to_8421
    import dec4221_pkg::*;
#(
    parameter int NDIG = 17
) (
    input  logic [4*NDIG-1:0] d4221,
    output logic [4*NDIG-1:0] d8421
);

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        assign d8421[4*i +: 4] = val4221(d4221[4*i +: 4]);
    end

endmodule

// File: rtl/dec4221_tree62.sv
module dec4221_tree62 #(
    parameter int DIGITS = 16
) (
    input  logic [4*DIGITS-1:0]     row0,
    input  logic [4*DIGITS-1:0]     row1,
    input  logic [4*DIGITS-1:0]     row2,
    input  logic [4*DIGITS-1:0]     row3,
    input  logic [4*DIGITS-1:0]     row4,
    input  logic [4*DIGITS-1:0]     row5,
    output logic [4*(DIGITS+1)-1:0] sum_row,
    output logic [4*(DIGITS+1)-1:0] dbl_row,
    output logic [4*(DIGITS+1)-1:0] sum_bcd,
    output logic [4*(DIGITS+1)-1:0] dbl_bcd
);

    localparam int ODIG = DIGITS + 1;
    localparam int OW   = 4 * ODIG;
    localparam int NIN  = 6;
    localparam int NLVL = 4;

    logic [OW-1:0] ext [NIN];
    logic [OW-1:0] s1a, d1a, s1b, d1b, s2, d2, s3, d3;
    logic [NLVL-1:0] lost;

    assign ext[0] = {4'b0000, row0};
    assign ext[1] = {4'b0000, row1};
    assign ext[2] = {4'b0000, row2};
    assign ext[3] = {4'b0000, row3};
    assign ext[4] = {4'b0000, row4};
    assign ext[5] = {4'b0000, row5};

    // level 1: six rows to four
    dec_csa_row #(.NDIG(ODIG)) u_l1a (
        .a_row(ext[0]), .b_row(ext[1]), .c_row(ext[2]),
        .s_row(s1a), .d_row(d1a), .top_cy(lost[0]));
    dec_csa_row #(.NDIG(ODIG)) u_l1b (
        .a_row(ext[3]), .b_row(ext[4]), .c_row(ext[5]),
        .s_row(s1b), .d_row(d1b), .top_cy(lost[1]));
    // level 2: four rows to three
    dec_csa_row #(.NDIG(ODIG)) u_l2 (
        .a_row(s1a), .b_row(s1b), .c_row(d1a),
        .s_row(s2), .d_row(d2), .top_cy(lost[2]));
    // level 3: three rows to two
    dec_csa_row #(.NDIG(ODIG)) u_l3 (
        .a_row(s2), .b_row(d1b), .c_row(d2),
        .s_row(s3), .d_row(d3), .top_cy(lost[3]));

    assign sum_row = s3;
    assign dbl_row = d3;

    dec4221_to_8421 #(.NDIG(ODIG)) u_cv_sum (.d4221(s3), .d8421(sum_bcd));
    dec4221_to_8421 #(.NDIG(ODIG)) u_cv_dbl (.d4221(d3), .d8421(dbl_bcd));

    always_comb begin
        // R5
        no_top_loss_chk: assert (lost == '0);
        // R7
        lsb_clear_chk: assert (dbl_row[0] == 1'b0);
    end

endmodule

// File: tb/dec4221_tree62_tb.sv
module dec4221_tree62_tb;

    localparam int D  = 16;
    localparam int OD = D + 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [4*D-1:0]  r [6];
    logic [4*OD-1:0] sum_row, dbl_row, sum_bcd, dbl_bcd;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    dec4221_tree62 #(.DIGITS(D)) u_dut (
        .row0(r[0]), .row1(r[1]), .row2(r[2]),
        .row3(r[3]), .row4(r[4]), .row5(r[5]),
        .sum_row(sum_row), .dbl_row(dbl_row),
        .sum_bcd(sum_bcd), .dbl_bcd(dbl_bcd));

    // 4221 word value: per digit 4*b3 + 2*b2 + 2*b1 + b0
    function automatic longint unsigned w4221(input logic [4*OD-1:0] w);
        longint unsigned acc = 0;
        for (int i = OD - 1; i >= 0; i--)
            acc = acc * 10 + 4 * w[4*i+3] + 2 * w[4*i+2] + 2 * w[4*i+1] + w[4*i];
        return acc;
    endfunction

    // 8421 word value; returns a huge marker if any digit exceeds 9
    function automatic longint unsigned w8421(input logic [4*OD-1:0] w);
        longint unsigned acc = 0;
        for (int i = OD - 1; i >= 0; i--) begin
            if (w[4*i +: 4] > 4'd9) return 64'hFFFF_FFFF_FFFF_FFFF;
            acc = acc * 10 + w[4*i +: 4];
        end
        return acc;
    endfunction

    task automatic check(input string req, input longint unsigned act,
                         input longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // apply a vector and check R4, R6, R7 at the falling edge
    task automatic run_vec(input string tag);
        longint unsigned tot = 0;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 6; k++) tot += w4221({4'b0000, r[k]});
        check({"R4 total ", tag}, w4221(sum_row) + w4221(dbl_row), tot);
        check({"R6 sum_bcd ", tag}, w8421(sum_bcd), w4221(sum_row));
        check({"R6 dbl_bcd ", tag}, w8421(dbl_bcd), w4221(dbl_row));
        check({"R7 dbl lsb ", tag}, 64'(dbl_row[0]), 0);
    endtask

    function automatic logic [4*D-1:0] fill(input logic [3:0] p);
        logic [4*D-1:0] w;
        for (int i = 0; i < D; i++) w[4*i +: 4] = p;
        return w;
    endfunction

    initial begin
        for (int k = 0; k < 6; k++) r[k] = '0;
        @(negedge clk);
        // R9 all-zero inputs
        check("R9 sum_row zero", 64'(sum_row != '0), 0);
        check("R9 dbl_row zero", 64'(dbl_row != '0), 0);
        check("R9 sum_bcd zero", 64'(sum_bcd != '0), 0);
        check("R9 dbl_bcd zero", 64'(dbl_bcd != '0), 0);

        // R5 all nines (1111) everywhere: total 6*(10^16-1)
        for (int k = 0; k < 6; k++) r[k] = fill(4'b1111);
        run_vec("R5 nines");
        check("R5 max total", w4221(sum_row) + w4221(dbl_row), 64'd59999999999999994);

        // R8 redundant codes: 0110 and 1000 both 4
        for (int k = 0; k < 6; k++) r[k] = fill(4'b0110);
        run_vec("R8 0110");
        check("R8 fours 0110", w4221(sum_row) + w4221(dbl_row), 64'd26666666666666664);
        for (int k = 0; k < 6; k++) r[k] = fill(4'b1000);
        run_vec("R8 1000");
        check("R8 fours 1000", w4221(sum_row) + w4221(dbl_row), 64'd26666666666666664);

        // R2 R3 single active row, then sparse patterns
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 6; j++) r[j] = '0;
            r[k] = fill(4'b1011);
            run_vec("R2 R3 single row");
        end

        // R1 random raw 4-bit patterns, fixed seed
        void'($urandom(32'd20240611));
        for (int n = 0; n < 400; n++) begin
            for (int k = 0; k < 6; k++)
                r[k] = {$urandom, $urandom};
            if (n % 5 == 0) r[n % 6] = '0;
            run_vec("R1 random");
        end

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

endmodule